// File: doc/BRIEF.md
# Interrupt CPU Interface with Split Priority Drop and Deactivation

This block sits between a set of interrupt sources and one processor core. It holds a pending bit for every interrupt it knows. It picks the most urgent candidate that is pending and not active, compares that candidate against a software priority mask and against the current running priority, and raises the core's interrupt request line when the candidate wins both comparisons. Software claims the interrupt with an acknowledge read, which returns the interrupt's ID. Software then retires it with an end-of-interrupt write, and in split mode it also issues a separate deactivate write.

The running priority comes from a stack. Each acknowledge pushes the priority of the interrupt it claims, and each end-of-interrupt write pops one entry. In combined mode (split bit 0), the end-of-interrupt write also makes the named interrupt inactive. In split mode (split bit 1), the end-of-interrupt write only lowers the running priority. The interrupt stays active and cannot be presented again until its ID is written to the deactivate port. This lets a handler give up its priority level early while the interrupt itself stays owned, for example while it is passed on to a guest.

Line interrupts use IDs 0 to NUM_LINES-1, and the first 16 of these are software-generated. Message interrupts use IDs 8192 and up. They have no active state: the end-of-interrupt write completes them, and a deactivate write that names them has no effect. ID 1023 is the "nothing to take" answer.

Top module: `irqc_cpu_if`

## Requirements
- R1: After reset, irq_o is 0, rpr_o is 0xFF, the priority mask is 0x00, both control bits are 0, ack_id_o is 1023, and no interrupt is pending or active.
- R2: irq_o is 1 only when all of these hold: the group-enable bit is 1, and the best candidate's priority is numerically lower than both the priority mask and rpr_o. A lower number means more urgent.
- R3: ack_id_o gives the ID of the pending, non-active interrupt with the lowest priority value, with ties going to the lowest ID. An acknowledge read while irq_o is 1 clears that interrupt's pending bit, marks it active if it is a line interrupt, and makes rpr_o equal to its priority on the next cycle.
- R4: When irq_o is 0, ack_id_o is 1023, and an acknowledge read changes no state.
- R5: With the split bit at 0, an end-of-interrupt write pops one running priority and makes the named line interrupt inactive, so that it can be taken again.
- R6: With the split bit at 1, an end-of-interrupt write pops one running priority and leaves the named interrupt active. Other interrupts at that priority become eligible. The still-active interrupt is not presented, even if it becomes pending again.
- R7: A deactivate write that names a line interrupt clears its active state in either mode.
- R8: Message interrupt j uses ID 8192+j. It never becomes active, it can be acknowledged again once it is pending again, and a deactivate write that names it changes nothing.
- R9: An end-of-interrupt write while the stack is empty is ignored entirely: rpr_o stays 0xFF, and no interrupt is deactivated.
- R10: Nesting is supported. A more urgent interrupt preempts a running one, and each end-of-interrupt write restores the priority that was running before the matching acknowledge. A full stack blocks any further signalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_set_i | input | NUM_LINES+NUM_MSG | One bit per interrupt; a 1 sets that interrupt's pending bit |
| prio_i | input | 8*(NUM_LINES+NUM_MSG) | Priority of each interrupt, 8 bits each, lowest index first |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_split_eoi | input | 1 | New value of the split bit (1 = priority drop and deactivation are separate writes) |
| ctl_grp_en | input | 1 | New value of the group-enable bit |
| pmr_we | input | 1 | Write strobe for the priority mask |
| pmr_val | input | 8 | New value of the priority mask |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_id_o | output | 14 | ID that an acknowledge read returns in this cycle |
| eoi_we | input | 1 | End-of-interrupt write strobe (ignored in a cycle that also has ack_rd) |
| eoi_id | input | 14 | ID carried by the end-of-interrupt write |
| dir_we | input | 1 | Deactivate write strobe |
| dir_id | input | 14 | ID carried by the deactivate write |
| irq_o | output | 1 | Interrupt request to the core |
| rpr_o | output | 8 | Running priority (0xFF when idle) |

## Verification
The bench targets the corner cases where a wrong design would misbehave in ways that software would notice:
- An interrupt that stays active after a split-mode end-of-interrupt write must not be presented again. A design that merged drop and deactivation would present it a second time.
- Two interrupts at the same priority must resolve to the lower ID. Getting this wrong flips the order in which IDs are returned.
- An end-of-interrupt write with an empty stack must do nothing. A faulty design would underflow rpr_o or silently clear an active bit.
- A deactivate write that names a message interrupt must be ignored. A faulty design would corrupt a line interrupt that shares its index.
- The bench also nests preemption and checks that each pop restores the outer priority exactly.
- Long random mixes of pends, acknowledges, retirements, deactivations, mask changes and mode changes are compared cycle by cycle against a reference model.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared widths, special IDs and types for the interrupt CPU interface.
// Assumes 8-bit priorities and a 14-bit ID space.
package irqc_pkg;
    localparam int ID_W   = 14;
    localparam int PRIO_W = 8;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam irq_id_t ID_NONE   = irq_id_t'(1023);
    localparam irq_id_t ID_MSG_LO = irq_id_t'(8192);
    localparam prio_t   PRIO_IDLE = prio_t'(8'hFF);
endpackage

// File: rtl/irqc_id_decode.sv
// Module irqc_id_decode
// Maps a software-visible interrupt ID to an internal entry index.
// Assumes line IDs 0..NUM_LINES-1 map to entries 0..NUM_LINES-1, and
// message IDs 8192..8192+NUM_MSG-1 map to the entries that follow.
// IDs outside both ranges give hit = 0.
module irqc_id_decode
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_MSG   = 4,
    localparam int NUM_ENT  = NUM_LINES + NUM_MSG,
    localparam int IDX_W    = $clog2(NUM_ENT)
) (
    input  irq_id_t           id,
    output logic              hit,
    output logic              is_line,
    output logic [IDX_W-1:0]  idx
);
    localparam irq_id_t LINE_LIM = irq_id_t'(NUM_LINES);
    localparam irq_id_t MSG_HI   = irq_id_t'(8192 + NUM_MSG);

    irq_id_t msg_rel;

    // Decode the ID into its range and its entry index.
    always_comb begin
        msg_rel = id - ID_MSG_LO + LINE_LIM;
        hit     = 1'b0;
        is_line = 1'b0;
        idx     = '0;
        if (id < LINE_LIM) begin
            hit     = 1'b1;
            is_line = 1'b1;
            idx     = id[IDX_W-1:0];
        end else if (id >= ID_MSG_LO && id < MSG_HI) begin
            hit = 1'b1;
            idx = msg_rel[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/irqc_select.sv
// Module irqc_select
// Finds the most urgent requesting entry. The lowest priority value wins,
// and on a tie the lowest index wins.
// Assumes the caller applies the mask and running-priority checks.
module irqc_select
    import irqc_pkg::*;
#(
    parameter int NUM_ENT = 36,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0] req,
    input  prio_t              prio [NUM_ENT],
    output logic               found,
    output logic [IDX_W-1:0]   best_idx,
    output prio_t              best_prio
);
    // Linear scan; a later entry replaces the current best only when strictly more urgent.
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = PRIO_IDLE;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (req[i] && (!found || prio[i] < best_prio)) begin
                found     = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irqc_prio_stack.sv
// Module irqc_prio_stack
// Stack of running priorities. The top entry is the running priority,
// and 0xFF is reported when the stack is empty.
// Assumes the caller never pushes and pops in the same cycle, never pushes
// when full, and never pops when empty.
module irqc_prio_stack
    import irqc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  prio_t push_prio,
    input  logic  pop,
    output prio_t top,
    output logic  empty,
    output logic  full
);
    prio_t             mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  top_ptr;

    assign top_ptr = cnt_q[PTR_W-1:0] - 1'b1;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign top     = empty ? PRIO_IDLE : mem[top_ptr];

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push)
            cnt_q <= cnt_q + 1'b1;
        else if (pop)
            cnt_q <= cnt_q - 1'b1;
    end

    // Store the pushed priority in the next free slot.
    always_ff @(posedge clk) begin
        if (push)
            mem[cnt_q[PTR_W-1:0]] <= push_prio;
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full) else $error("push on full stack"); // R10
    AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) else $error("pop on empty stack"); // R9
    AST_PUSH_MORE_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> push_prio < top) else $error("push not above running priority"); // R2
endmodule

// File: rtl/irqc_entry_state.sv
// Module irqc_entry_state
// Pending bits for every entry and active bits for line entries only.
// Message entries report active = 0 at all times.
// Assumes set wins over clear for pending, and set wins over clear for active.
module irqc_entry_state #(
    parameter int NUM_LINES = 32,
    parameter int NUM_MSG   = 4,
    localparam int NUM_ENT  = NUM_LINES + NUM_MSG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] pend_set,
    input  logic [NUM_ENT-1:0] take,
    input  logic [NUM_ENT-1:0] deact,
    output logic [NUM_ENT-1:0] pend_o,
    output logic [NUM_ENT-1:0] act_o
);
    logic [NUM_ENT-1:0]   pend_q;
    logic [NUM_LINES-1:0] line_act_q;

    assign pend_o = pend_q;
    assign act_o  = {{NUM_MSG{1'b0}}, line_act_q};

    // Update pending: acknowledge clears it, a new request sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~take) | pend_set;
    end

    // Update line active state: deactivation clears it, acknowledge sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_act_q <= '0;
        else
            line_act_q <= (line_act_q & ~deact[NUM_LINES-1:0]) | take[NUM_LINES-1:0];
    end
endmodule

// File: rtl/irqc_cpu_if.sv
// Module irqc_cpu_if
// Per-core interrupt interface. It presents the best eligible interrupt,
// claims it on acknowledge, and retires it through end-of-interrupt and
// deactivate writes, with an optional split between the two.
// Assumes software does not issue an acknowledge and an end-of-interrupt
// in the same cycle; if it does, the end-of-interrupt is dropped.
// Assumes NUM_LINES <= 1020 and NUM_MSG >= 1.
module irqc_cpu_if
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_MSG   = 4,
    parameter int DEPTH     = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_LINES+NUM_MSG-1:0]       pend_set_i,
    input  logic [(NUM_LINES+NUM_MSG)*8-1:0]   prio_i,
    input  logic                               ctl_we,
    input  logic                               ctl_split_eoi,
    input  logic                               ctl_grp_en,
    input  logic                               pmr_we,
    input  logic [7:0]                         pmr_val,
    input  logic                               ack_rd,
    output logic [13:0]                        ack_id_o,
    input  logic                               eoi_we,
    input  logic [13:0]                        eoi_id,
    input  logic                               dir_we,
    input  logic [13:0]                        dir_id,
    output logic                               irq_o,
    output logic [7:0]                         rpr_o
);
    localparam int NUM_ENT = NUM_LINES + NUM_MSG;
    localparam int IDX_W   = $clog2(NUM_ENT);

    logic  split_q, grp_q;
    prio_t pmr_q;

    prio_t              prio_arr [NUM_ENT];
    logic [NUM_ENT-1:0] pend_vec, act_vec, take_vec, deact_vec;
    logic               sel_found;
    logic [IDX_W-1:0]   sel_idx;
    prio_t              sel_prio;
    prio_t              run_prio;
    logic               stk_empty, stk_full;
    logic               eligible, ack_fire, eoi_fire;
    logic               eoi_hit, eoi_line, dir_hit, dir_line;
    logic [IDX_W-1:0]   eoi_idx, dir_idx;
    irq_id_t            sel_id;

    // Unpack the flat priority bus into one entry per interrupt.
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_prio
        assign prio_arr[g] = prio_i[g*PRIO_W +: PRIO_W];
    end

    // Hold the control bits and the priority mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q <= 1'b0;
            grp_q   <= 1'b0;
            pmr_q   <= '0;
        end else begin
            if (ctl_we) begin
                split_q <= ctl_split_eoi;
                grp_q   <= ctl_grp_en;
            end
            if (pmr_we)
                pmr_q <= pmr_val;
        end
    end

    irqc_entry_state #(.NUM_LINES(NUM_LINES), .NUM_MSG(NUM_MSG)) u_state (
        .clk(clk), .rst_n(rst_n), .pend_set(pend_set_i), .take(take_vec),
        .deact(deact_vec), .pend_o(pend_vec), .act_o(act_vec)
    );

    irqc_select #(.NUM_ENT(NUM_ENT)) u_sel (
        .req(pend_vec & ~act_vec), .prio(prio_arr), .found(sel_found),
        .best_idx(sel_idx), .best_prio(sel_prio)
    );

    irqc_prio_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(ack_fire), .push_prio(sel_prio),
        .pop(eoi_fire), .top(run_prio), .empty(stk_empty), .full(stk_full)
    );

    irqc_id_decode #(.NUM_LINES(NUM_LINES), .NUM_MSG(NUM_MSG)) u_dec_eoi (
        .id(eoi_id), .hit(eoi_hit), .is_line(eoi_line), .idx(eoi_idx)
    );

    irqc_id_decode #(.NUM_LINES(NUM_LINES), .NUM_MSG(NUM_MSG)) u_dec_dir (
        .id(dir_id), .hit(dir_hit), .is_line(dir_line), .idx(dir_idx)
    );

    // Decide whether the best candidate may be signalled and what ID it carries.
    always_comb begin
        eligible = grp_q && sel_found && !stk_full &&
                   (sel_prio < pmr_q) && (sel_prio < run_prio);
        if (sel_idx < IDX_W'(NUM_LINES))
            sel_id = irq_id_t'(sel_idx);
        else
            sel_id = ID_MSG_LO + irq_id_t'(sel_idx) - irq_id_t'(NUM_LINES);
    end

    assign ack_fire = ack_rd && eligible;
    assign eoi_fire = eoi_we && !ack_rd && !stk_empty;
    assign irq_o    = eligible;
    assign ack_id_o = eligible ? sel_id : ID_NONE;
    assign rpr_o    = run_prio;

    // Build the one-hot claim and deactivation vectors for this cycle.
    always_comb begin
        take_vec  = '0;
        deact_vec = '0;
        if (ack_fire)
            take_vec[sel_idx] = 1'b1;
        if (dir_we && dir_hit && dir_line)
            deact_vec[dir_idx] = 1'b1;
        if (eoi_fire && !split_q && eoi_hit && eoi_line)
            deact_vec[eoi_idx] = 1'b1;
    end

    AST_IRQ_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !act_vec[sel_idx]) else $error("active interrupt presented"); // R6
    AST_ACK_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && sel_idx < IDX_W'(NUM_LINES)) |=> act_vec[$past(sel_idx)])
        else $error("acknowledged line not active"); // R3
    AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !pend_set_i[sel_idx]) |=> !pend_vec[$past(sel_idx)])
        else $error("acknowledged interrupt still pending"); // R3
    AST_SPLIT_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && split_q && eoi_line && act_vec[eoi_idx] &&
         !(dir_we && dir_line && dir_idx == eoi_idx)) |=> act_vec[$past(eoi_idx)])
        else $error("split-mode EOI deactivated"); // R6
    AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_empty |-> rpr_o == PRIO_IDLE) else $error("idle priority wrong"); // R1
endmodule

// File: tb/irqc_cpu_if_bench.sv
`timescale 1ns/1ps
module irqc_cpu_if_bench;
    localparam int NL = 32;
    localparam int NM = 4;
    localparam int NE = NL + NM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NE-1:0]   pend_set = '0;
    logic [NE*8-1:0] prio_flat;
    logic ctl_we = 0, ctl_split = 0, ctl_grp = 0, pmr_we = 0;
    logic [7:0] pmr_v = 0;
    logic ack_rd = 0, eoi_we = 0, dir_we = 0;
    logic [13:0] eoi_id = 0, dir_id = 0, ack_id;
    logic irq;
    logic [7:0] rpr;

    int pr [NE];
    bit m_pend [NE];
    bit m_act [NE];
    int sp [16];
    int sid [16];
    int cnt = 0;
    bit m_split = 0, m_grp = 0;
    int m_pmr = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < NE; i++) prio_flat[i*8 +: 8] = pr[i][7:0];

    irqc_cpu_if #(.NUM_LINES(NL), .NUM_MSG(NM), .DEPTH(16)) u_irqc_cpu_if (
        .clk(clk), .rst_n(rst_n), .pend_set_i(pend_set), .prio_i(prio_flat),
        .ctl_we(ctl_we), .ctl_split_eoi(ctl_split), .ctl_grp_en(ctl_grp),
        .pmr_we(pmr_we), .pmr_val(pmr_v), .ack_rd(ack_rd), .ack_id_o(ack_id),
        .eoi_we(eoi_we), .eoi_id(eoi_id), .dir_we(dir_we), .dir_id(dir_id),
        .irq_o(irq), .rpr_o(rpr)
    );

    function automatic int id_of(int k);
        return (k < NL) ? k : 8192 + k - NL;
    endfunction

    function automatic int idx_of(int id);
        if (id >= 0 && id < NL) return id;
        if (id >= 8192 && id < 8192 + NM) return NL + id - 8192;
        return -1;
    endfunction

    function automatic int m_rpr();
        return (cnt == 0) ? 255 : sp[cnt-1];
    endfunction

    // Expected entry for an acknowledge, or -1 when nothing may be signalled.
    function automatic int m_best();
        int b = -1;
        for (int i = 0; i < NE; i++)
            if (m_pend[i] && !m_act[i] && (b < 0 || pr[i] < pr[b])) b = i;
        if (b < 0 || !m_grp || cnt >= 16 || pr[b] >= m_pmr || pr[b] >= m_rpr()) return -1;
        return b;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [NE-1:0] ps, input bit a, input bit e, input int eid,
                        input bit d, input int did);
        int b, k;
        @(negedge clk);
        pend_set = ps; ack_rd = a; eoi_we = e; eoi_id = eid[13:0];
        dir_we = d; dir_id = did[13:0];
        b = m_best();
        @(posedge clk);
        #1;
        pend_set = '0; ack_rd = 0; eoi_we = 0; dir_we = 0;
        if (d) begin k = idx_of(did); if (k >= 0 && k < NL) m_act[k] = 0; end
        if (e && !a && cnt > 0) begin
            cnt--;
            if (!m_split) begin k = idx_of(eid); if (k >= 0 && k < NL) m_act[k] = 0; end
        end
        if (a && b >= 0) begin
            m_pend[b] = 0;
            if (b < NL) m_act[b] = 1;
            sp[cnt] = pr[b]; sid[cnt] = id_of(b); cnt++;
        end
        for (int i = 0; i < NE; i++) if (ps[i]) m_pend[i] = 1;
    endtask

    task automatic pend(input int k); step(NE'(1) << k, 0, 0, 0, 0, 0); endtask
    task automatic ack();             step('0, 1, 0, 0, 0, 0); endtask
    task automatic eoi(input int id); step('0, 0, 1, id, 0, 0); endtask
    task automatic dir(input int id); step('0, 0, 0, 0, 1, id); endtask

    task automatic set_ctl(input bit s, input bit g);
        @(negedge clk); ctl_we = 1; ctl_split = s; ctl_grp = g;
        @(posedge clk); #1; ctl_we = 0; m_split = s; m_grp = g;
    endtask

    task automatic set_pmr(input int v);
        @(negedge clk); pmr_we = 1; pmr_v = v[7:0];
        @(posedge clk); #1; pmr_we = 0; m_pmr = v;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd20150825);
        for (int i = 0; i < NE; i++) begin pr[i] = 128; m_pend[i] = 0; m_act[i] = 0; end
        pr[5] = 64; pr[20] = 64; pr[7] = 48; pr[9] = 48; pr[3] = 80;
        pr[12] = 96; pr[2] = 16; pr[4] = 16; pr[NL+1] = 32;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 irq", irq, 0); chk("R1 rpr", rpr, 255); chk("R1 ack_id", ack_id, 1023);

        // Masking and group enable, plus tie-break toward the lower ID.
        pend(5);
        chk("R2 masked irq", irq, 0);
        set_pmr(240); set_ctl(0, 1);
        chk("R2 irq", irq, 1);
        pend(20);
        chk("R3 tie lowest id", ack_id, 5);
        ack();
        chk("R3 rpr after ack", rpr, 64);
        chk("R4 same prio blocked", ack_id, 1023);
        chk("R4 irq low", irq, 0);
        ack();
        chk("R4 empty ack no effect", rpr, 64);
        eoi(5);
        chk("R5 drop", rpr, 255);
        chk("R5 next", ack_id, 20);
        pend(5);
        chk("R5 retake", ack_id, 5);
        ack(); eoi(5); ack(); eoi(20);

        // Split mode: drop without deactivate, then deactivate.
        set_ctl(1, 1);
        step((NE'(1) << 7) | (NE'(1) << 9), 0, 0, 0, 0, 0);
        chk("R3 pick 7", ack_id, 7);
        ack(); eoi(7);
        chk("R6 drop", rpr, 255);
        chk("R6 same level eligible", ack_id, 9);
        ack(); pend(7);
        chk("R6 active not shown", ack_id, 1023);
        eoi(9);
        chk("R6 still active", ack_id, 1023);
        chk("R6 irq low", irq, 0);
        dir(7);
        chk("R7 deactivated", ack_id, 7);
        ack(); eoi(7); dir(7); dir(9); pend(9);
        chk("R7 deactivate restores", ack_id, 9);
        ack(); eoi(9); dir(9);

        // End-of-interrupt with an empty stack.
        pend(3); ack(); eoi(3);
        set_ctl(0, 1);
        eoi(3);
        chk("R9 rpr idle", rpr, 255);
        pend(3);
        chk("R9 no deactivate", ack_id, 1023);
        dir(3);
        chk("R7 dir in mode 0", ack_id, 3);
        ack(); eoi(3);

        // Message interrupts.
        set_ctl(1, 1);
        pend(NL + 1);
        chk("R8 msg id", ack_id, 8193);
        ack();
        chk("R8 rpr", rpr, 32);
        dir(8193);
        chk("R8 dir ignored", rpr, 32);
        eoi(8193);
        chk("R8 drop", rpr, 255);
        pend(NL + 1);
        chk("R8 no active", ack_id, 8193);
        ack(); eoi(8193);

        // Nesting.
        pend(12); ack();
        chk("R10 outer", rpr, 96);
        pend(2);
        chk("R10 preempt irq", irq, 1);
        chk("R10 preempt id", ack_id, 2);
        ack();
        chk("R10 inner", rpr, 16);
        eoi(2);
        chk("R10 restore", rpr, 96);
        eoi(12);
        chk("R10 idle", rpr, 255);
        dir(2); dir(12);

        // Strict mask compare.
        set_pmr(16); pend(4);
        chk("R2 equal mask", irq, 0);
        set_pmr(17);
        chk("R2 below mask", irq, 1);
        set_ctl(1, 0);
        chk("R2 group off", irq, 0);
        set_ctl(1, 1);
        ack(); eoi(4); dir(4);

        // Random mix against the model.
        for (int i = 0; i < NE; i++) pr[i] = 16 * (1 + ($urandom % 8));
        set_pmr(255);
        for (int n = 0; n < 4000; n++) begin
            logic [NE-1:0] ps;
            int sel, eid, did;
            ps = '0;
            if ($urandom % 10 < 4) ps[$urandom % NE] = 1'b1;
            sel = $urandom % 100;
            eid = (cnt > 0 && ($urandom % 5 != 0)) ? sid[cnt-1] : id_of($urandom % NE);
            did = ($urandom % 4 == 0) ? 8192 + ($urandom % NM) : ($urandom % NL);
            if (sel < 3) set_ctl($urandom % 2, ($urandom % 8) != 0);
            else if (sel < 5) set_pmr(($urandom % 2) ? 255 : 16 * (1 + ($urandom % 9)));
            else step(ps, sel < 40, sel >= 40 && sel < 65, eid, sel >= 65 && sel < 80, did);
            chk("R2 random irq", irq, (m_best() >= 0) ? 1 : 0);
            chk("R3 random ack_id", ack_id, (m_best() >= 0) ? id_of(m_best()) : 1023);
            chk("R10 random rpr", rpr, m_rpr());
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule